// File: doc/BRIEF.md
# Dual-Phase Interleaved Digital Pulse-Width Modulator

This block turns a duty word into switch commands for a two-phase synchronous buck power stage. Each phase feeds an external MOSFET driver through one PWM line and one driver-mode line. Both lines only ever encode three states: high-side switch on, low-side switch on, or both switches off. The duty word and the period are counts of clock ticks, 16 bits wide by default. A new duty word may be presented on every switching cycle. A programmable ceiling limits every pulse.

Two kinds of driver are supported. With a tri-state driver, the PWM line itself is released (its output enable drops) to turn both switches off, and the driver-mode line stays idle. With a driver that has a separate enable, the driver-mode line becomes that enable, and the PWM line only picks high side or low side.

The second phase can be added or dropped while the stage runs. When both phases run, the second phase is shifted by half a period, so the ripple at the output has twice the per-phase frequency. Duty, period and phase-count changes take effect only at a boundary, so no pulse is ever cut short. Dropping the conversion enable turns every switch off at once.

Top module: `dual_phase_dpwm`

## Requirements
- R1: While `en_i` is low, both phases show "both switches off" in the same cycle: `pwm_o` = 00, and `pwm_oe_o` = 00 in tri-state mode or `drv_en_o` = 00 in enable mode. While disabled, the phase-1 tick counter is held at 0. The period and clamped duty are reloaded every cycle, so the first cycle after enable is tick 0 of a fresh period.
- R2: Phase 1 repeats every P ticks, where P is the value of `period_i` taken at the last phase-1 boundary (the wrap from tick P-1 to tick 0). Any value below 2 is used as 2.
- R3: Phase 1 commands the high side (`pwm_o[0]` = 1) during ticks 0 to D-1 of each period and the low side for the rest. D is the clamped duty word sampled at the phase-1 boundary, so it may differ on every period.
- R4: The duty used by either phase is min(`duty_i`, `max_duty_i`).
- R5: Phase-2 periods start ceil(P/2) ticks after phase-1 periods start. Phase 2 commands its high side (`pwm_o[1]` = 1) for its first D2 ticks. D2 is the clamped duty sampled at the phase-2 boundary.
- R6: `ph2_i` is sampled only at the phase-2 boundary. A dropped phase 2 shows "both switches off". After enable, phase 2 stays off until its first boundary.
- R7: Tri-state mode (`mode_i` = 0) uses this encoding per phase: `pwm_oe_o` = 1 with `pwm_o` = 1 means high side on; `pwm_oe_o` = 1 with `pwm_o` = 0 means low side on; `pwm_oe_o` = 0 means both off. `drv_en_o` stays 00.
- R8: In enable mode (`mode_i` = 1), `pwm_oe_o` is 11. `drv_en_o[k]` is 1 when phase k is running, and `pwm_o[k]` then selects the high side (1) or the low side (0). When `drv_en_o[k]` is 0, `pwm_o[k]` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Conversion enable; low for a fault, the enable pin or a bus command |
| mode_i | input | 1 | Driver type: 0 tri-state PWM, 1 PWM plus enable |
| ph2_i | input | 1 | Request that phase 2 runs |
| period_i | input | W | Switching period in ticks |
| duty_i | input | W | High-side on-time in ticks |
| max_duty_i | input | W | Duty ceiling in ticks, below the period |
| pwm_o | output | 2 | PWM level per phase (bit 0 = phase 1) |
| pwm_oe_o | output | 2 | PWM output enable per phase; low releases the line to mid level |
| drv_en_o | output | 2 | Driver enable per phase (enable mode only) |

## Verification
Some properties are checked by the assertions on every cycle:
- every output is off while disabled;
- a dropped phase 2 is off;
- the encoding matches the selected driver mode;
- the tick counter stays below the period;
- a high-side pulse can only begin at its own phase's tick 0.

Other behaviour only the scenarios can show: the actual pulse widths, the clamp, the ceil(P/2) interleave offset, the boundary timing of duty and phase-count changes, and the minimum-period rule. The bench checks these by comparing against a cycle-level model and by measuring widths and edge spacing at the ports.

// File: rtl/dual_phase_dpwm.sv
module dual_phase_dpwm #(
  parameter int W       = 16,
  parameter int MIN_PER = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en_i,
  input  logic         mode_i,
  input  logic         ph2_i,
  input  logic [W-1:0] period_i,
  input  logic [W-1:0] duty_i,
  input  logic [W-1:0] max_duty_i,
  output logic [1:0]   pwm_o,
  output logic [1:0]   pwm_oe_o,
  output logic [1:0]   drv_en_o
);
  localparam logic [W-1:0] PMIN = W'(MIN_PER);
  localparam logic [W-1:0] ONE  = W'(1);

  logic [W-1:0] per_q, tick_q, d1_q, d2_q;
  logic         ph2_q;

  logic [W-1:0] duty_c, per_c, half, lag, tick2;
  logic         end1, end2;
  logic [1:0]   run, hi;

  assign duty_c = (duty_i > max_duty_i) ? max_duty_i : duty_i;
  assign per_c  = (period_i < PMIN) ? PMIN : period_i;
  assign half   = per_q >> 1;
  assign lag    = per_q - half;
  assign tick2  = (tick_q >= lag) ? tick_q - lag : tick_q + half;
  assign end1   = (tick_q == per_q - ONE);
  assign end2   = (tick_q == lag - ONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= PMIN;
      tick_q <= '0;
      d1_q   <= '0;
      d2_q   <= '0;
      ph2_q  <= 1'b0;
    end else if (!en_i) begin
      per_q  <= per_c;
      tick_q <= '0;
      d1_q   <= duty_c;
      ph2_q  <= 1'b0;
    end else begin
      if (end1) begin
        tick_q <= '0;
        per_q  <= per_c;
        d1_q   <= duty_c;
      end else begin
        tick_q <= tick_q + ONE;
      end
      if (end2) begin
        d2_q  <= duty_c;
        ph2_q <= ph2_i;
      end
    end
  end

  assign run      = {en_i & ph2_q, en_i};
  assign hi       = run & {tick2 < d2_q, tick_q < d1_q};
  assign pwm_o    = hi;
  assign pwm_oe_o = mode_i ? 2'b11 : run;
  assign drv_en_o = mode_i ? run : 2'b00;
endmodule

// File: rtl/dual_phase_dpwm_chk.sv
module dual_phase_dpwm_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         en_i,
  input logic         mode_i,
  input logic [1:0]   pwm_o,
  input logic [1:0]   pwm_oe_o,
  input logic [1:0]   drv_en_o,
  input logic [W-1:0] tick_q,
  input logic [W-1:0] per_q,
  input logic [W-1:0] tick2,
  input logic         ph2_q
);
  assert_off_when_disabled_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> (pwm_o == 2'b00 && (mode_i ? drv_en_o == 2'b00 : pwm_oe_o == 2'b00)));

  assert_tick_below_period_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick_q < per_q);

  assert_p1_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o[0]) |-> tick_q == '0);

  assert_p2_rise_at_offset_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwm_o[1]) |-> tick2 == '0);

  assert_dropped_phase_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ph2_q |-> (!pwm_o[1] && (mode_i ? !drv_en_o[1] : !pwm_oe_o[1])));

  assert_tri_mode_drv_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |-> drv_en_o == 2'b00);

  assert_en_mode_encoding_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_i |-> (pwm_oe_o == 2'b11 && (pwm_o & ~drv_en_o) == 2'b00));
endmodule

bind dual_phase_dpwm dual_phase_dpwm_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en_i(en_i), .mode_i(mode_i),
  .pwm_o(pwm_o), .pwm_oe_o(pwm_oe_o), .drv_en_o(drv_en_o),
  .tick_q(tick_q), .per_q(per_q), .tick2(tick2), .ph2_q(ph2_q)
);

// File: tb/tb_dual_phase_dpwm.sv
module tb_dual_phase_dpwm;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, mode = 1'b0, ph2 = 1'b0;
  logic [15:0] per = 16'd20, duty = 16'd0, maxd = 16'd18;
  logic [1:0] pwm, oe, drv;

  int vec = 0, fails = 0;
  string tag = "R1";
  bit done = 0;

  always #4 clk = ~clk;

  dual_phase_dpwm dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .mode_i(mode), .ph2_i(ph2),
    .period_i(per), .duty_i(duty), .max_duty_i(maxd),
    .pwm_o(pwm), .pwm_oe_o(oe), .drv_en_o(drv)
  );

  int mp = 2, mc = 0, md1 = 0, md2 = 0;
  bit ma2 = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mp = 2; mc = 0; md1 = 0; md2 = 0; ma2 = 0;
    end else begin
      int pc, dc, lg;
      bit e1, e2;
      pc = (int'(per) < 2) ? 2 : int'(per);
      dc = (duty > maxd) ? int'(maxd) : int'(duty);
      if (!en) begin
        mp = pc; mc = 0; md1 = dc; ma2 = 0;
      end else begin
        lg = mp - mp / 2;
        e1 = (mc == mp - 1);
        e2 = (mc == lg - 1);
        if (e2) begin md2 = dc; ma2 = ph2; end
        if (e1) begin mc = 0; mp = pc; md1 = dc; end
        else mc = mc + 1;
      end
    end
  end

  task automatic check(string t, int act, int exp);
    vec++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", t, act, exp);
    end
  endtask

  task automatic step();
    int lg, c2;
    bit on1, on2, h1, h2;
    logic [1:0] epwm, eoe, edrv;
    @(negedge clk); #1;
    lg  = mp - mp / 2;
    c2  = (mc >= lg) ? mc - lg : mc + mp / 2;
    on1 = en;
    on2 = en && ma2;
    h1  = on1 && (mc < md1);
    h2  = on2 && (c2 < md2);
    epwm = {h2, h1};
    eoe  = mode ? 2'b11 : {on2, on1};
    edrv = mode ? {on2, on1} : 2'b00;
    vec++;
    if (pwm !== epwm || oe !== eoe || drv !== edrv) begin
      fails++;
      $display("FAIL %s: actual pwm=%b oe=%b drv=%b expected pwm=%b oe=%b drv=%b",
               tag, pwm, oe, drv, epwm, eoe, edrv);
    end
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic width(int n, int ph, output int hcnt, output int ocnt);
    hcnt = 0; ocnt = 0;
    for (int i = 0; i < n; i++) begin
      step();
      if (pwm[ph] === 1'b1) hcnt++;
      if (oe[ph] === 1'b1) ocnt++;
    end
  endtask

  task automatic offset(output int d);
    int t1, t2;
    logic p0, p1;
    t1 = -1; t2 = -1; d = -1;
    p0 = pwm[0]; p1 = pwm[1];
    for (int i = 0; i < 200 && t2 < 0; i++) begin
      step();
      if (t1 < 0 && p0 === 1'b0 && pwm[0] === 1'b1) t1 = i;
      else if (t1 >= 0 && p1 === 1'b0 && pwm[1] === 1'b1) t2 = i;
      p0 = pwm[0]; p1 = pwm[1];
    end
    if (t1 >= 0 && t2 >= 0) d = t2 - t1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vec, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int h, o, d;
    tag = "R1";
    run(3);
    @(negedge clk); #1;
    rst_n = 1'b1;
    run(3);
    check("R1 reset pwm", int'(pwm), 0);
    check("R1 reset oe tri", int'(oe), 0);
    check("R1 reset drv", int'(drv), 0);

    tag = "R3"; per = 16'd20; duty = 16'd7; maxd = 16'd18; en = 1'b1;
    run(45);
    width(20, 0, h, o);
    check("R3 phase1 width", h, 7);
    check("R7 tri phase1 driven every tick", o, 20);
    check("R7 tri drv idle", int'(drv), 0);

    tag = "R3";
    for (int k = 0; k < 6; k++) begin
      duty = 16'(2 + 3 * k);
      run(20);
    end
    duty = 16'd3;
    run(40);
    width(20, 0, h, o);
    check("R3 new duty width", h, 3);

    tag = "R4"; duty = 16'd19; maxd = 16'd12;
    run(40);
    width(20, 0, h, o);
    check("R4 clamped width", h, 12);

    tag = "R5"; maxd = 16'd18; duty = 16'd6; ph2 = 1'b1;
    run(60);
    offset(d);
    check("R5 offset P=20", d, 10);
    width(20, 1, h, o);
    check("R5 phase2 width", h, 6);

    tag = "R6"; ph2 = 1'b0;
    run(50);
    width(20, 1, h, o);
    check("R6 dropped phase2 high count", h, 0);
    check("R6 dropped phase2 released", o, 0);

    tag = "R2"; per = 16'd21;
    run(50);
    width(21, 0, h, o);
    check("R2 period 21 width", h, 6);
    tag = "R5"; ph2 = 1'b1;
    run(60);
    offset(d);
    check("R5 offset P=21", d, 11);

    tag = "R8"; mode = 1'b1;
    run(60);
    check("R8 drv both enabled", int'(drv), 3);
    check("R8 oe held", int'(oe), 3);
    width(21, 1, h, o);
    check("R8 phase2 width", h, 6);

    tag = "R1"; en = 1'b0;
    step();
    check("R1 disable pwm", int'(pwm), 0);
    check("R1 disable drv", int'(drv), 0);
    run(5);
    tag = "R6"; en = 1'b1;
    step();
    check("R6 phase2 waits after enable", int'(drv[1]), 0);
    run(60);

    tag = "R2"; mode = 1'b0; ph2 = 1'b0; en = 1'b0;
    per = 16'd1; duty = 16'd1; maxd = 16'd1;
    run(5);
    en = 1'b1;
    run(10);
    width(2, 0, h, o);
    check("R2 minimum period width", h, 1);
    width(10, 0, h, o);
    check("R2 minimum period ratio", h, 5);

    summary();
  end
endmodule